// File: doc/BRIEF.md
# One-Hot Addressed Register File with Write Bypass

This block is a small synchronous register file with one write port and a set of read ports (two by default). Every port picks its entry with a one-hot select vector rather than a binary address: bit n of a select vector stands for entry n. A write is committed to storage on the rising clock edge.

Reads are purely combinational. No register sits between the select vector and the read data. When a read port selects the entry that the write port is writing in the same cycle, the port returns the incoming write data before the edge rather than the old contents. A read port with no select bit set drives all zeros. This makes it easy to OR several ports' results together downstream.

The stored contents have no reset value. The owner must write an entry before relying on what it returns.

Top module: `onehot_regfile`

## Requirements
- R1: When write-select bit n is 1 at a rising edge (reset low), entry n takes `wr_data`. A later read selecting entry n returns that value until entry n is written again.
- R2: When the write-select vector is all zero at an edge, no entry changes. When write-select bit n is 0, entry n keeps its value.
- R3: When a read port's select vector has bit n set and write-select bit n is also set in the same cycle, that port's output uses `wr_data` for entry n in that same cycle, before the clock edge.
- R4: A read port whose select vector is all zero drives zero on its data output, including while reset is asserted.
- R5: The read ports are independent. Port 0 and port 1 may select different entries in the same cycle as a write to a third entry, and each returns its own entry's value.
- R6: Read data follows a change of the read-select vector within the same cycle, with zero cycles of latency.
- R7: A read-select vector with several bits set returns the bitwise OR of all selected entries. Any entry being written in that cycle contributes `wr_data` instead of its stored value.
- R8: A write-select vector with several bits set writes `wr_data` into every selected entry at the edge.
- R9: Port k occupies bits [k*ENTRIES +: ENTRIES] of `rd_sel` and bits [k*WIDTH +: WIDTH] of `rd_data`. Within a select vector, bit n addresses entry n.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, writes commit on the rising edge |
| rst | input | 1 | Synchronous active-high reset; storage contents are not cleared |
| wr_sel | input | ENTRIES | One-hot write select; all zero means no write |
| wr_data | input | WIDTH | Data to write |
| rd_sel | input | RD_PORTS*ENTRIES | Read select vectors, one ENTRIES-wide slice per port |
| rd_data | output | RD_PORTS*WIDTH | Read data, one WIDTH-wide slice per port |

## Verification
Some properties are checked by assertions on every cycle:
- every selected entry takes the write data at the edge;
- every unselected entry holds its value;
- an idle read port shows zero;
- a port that selects exactly the entry being written returns the write data.

Other behaviours only the bench scenarios can show:
- zero-latency response to a select change within a cycle;
- the independence of the two ports while a third entry is written;
- OR-merging of multi-bit reads that mix stored and forwarded entries;
- multi-entry writes.

The bench compares both ports against a behavioural model on every cycle, over directed and pseudo-random stimulus.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_ENTRIES_DEF  = 8;
  localparam int RF_WIDTH_DEF    = 32;
  localparam int RF_RD_PORTS_DEF = 2;
endpackage

// File: rtl/rf_storage.sv
module rf_storage #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              wr_sel,
  input  logic [WIDTH-1:0]                wr_data,
  output logic [ENTRIES-1:0][WIDTH-1:0]   q
);
  logic [WIDTH-1:0] mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_sel[i]) mem[i] <= wr_data;
    end
    assign q[i] = mem[i];

    // R1, R8: a selected entry holds the write data after the edge
    p_commit_r1: assert property (@(posedge clk) disable iff (rst)
      wr_sel[i] |=> (q[i] == $past(wr_data)));
    // R2: an unselected entry keeps its value
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
      !wr_sel[i] |=> $stable(q[i]));
  end
endmodule

// File: rtl/rf_bypass.sv
module rf_bypass #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 32
) (
  input  logic [ENTRIES-1:0]              wr_sel,
  input  logic [WIDTH-1:0]                wr_data,
  input  logic [ENTRIES-1:0][WIDTH-1:0]   q,
  output logic [ENTRIES-1:0][WIDTH-1:0]   view
);
  for (genvar i = 0; i < ENTRIES; i++) begin : g_view
    assign view[i] = wr_sel[i] ? wr_data : q[i];
  end
endmodule

// File: rtl/rf_rdport.sv
module rf_rdport #(
  parameter int ENTRIES = 8,
  parameter int WIDTH   = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [ENTRIES-1:0]              sel,
  input  logic [ENTRIES-1:0][WIDTH-1:0]   view,
  output logic [WIDTH-1:0]                data
);
  always_comb begin
    data = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel[i]) data = data | view[i];
    end
  end

  // R4: idle port drives zero
  p_idle_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> (data == '0));
endmodule

// File: rtl/onehot_regfile.sv
module onehot_regfile
  import rf_pkg::*;
#(
  parameter int ENTRIES  = RF_ENTRIES_DEF,
  parameter int WIDTH    = RF_WIDTH_DEF,
  parameter int RD_PORTS = RF_RD_PORTS_DEF
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ENTRIES-1:0]            wr_sel,
  input  logic [WIDTH-1:0]              wr_data,
  input  logic [RD_PORTS*ENTRIES-1:0]   rd_sel,
  output logic [RD_PORTS*WIDTH-1:0]     rd_data
);
  logic [ENTRIES-1:0][WIDTH-1:0] q;
  logic [ENTRIES-1:0][WIDTH-1:0] view;

  rf_storage #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_storage (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data), .q(q)
  );

  rf_bypass #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_bypass (
    .wr_sel(wr_sel), .wr_data(wr_data), .q(q), .view(view)
  );

  for (genvar k = 0; k < RD_PORTS; k++) begin : g_port
    logic [ENTRIES-1:0] psel;
    logic [WIDTH-1:0]   pdata;
    assign psel = rd_sel[k*ENTRIES +: ENTRIES];

    rf_rdport #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_rdport (
      .clk(clk), .rst(rst), .sel(psel), .view(view), .data(pdata)
    );
    assign rd_data[k*WIDTH +: WIDTH] = pdata;

    // R3: a one-hot read of the entry being written returns the write data
    p_forward_r3: assert property (@(posedge clk) disable iff (rst)
      ($onehot(psel) && ((psel & wr_sel) != '0)) |-> (pdata == wr_data));
  end
endmodule

// File: tb/onehot_regfile_bench.sv
module onehot_regfile_bench;
  localparam int N = 8;
  localparam int W = 32;
  localparam int P = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   wr_sel = '0;
  logic [W-1:0]   wr_data = '0;
  logic [P*N-1:0] rd_sel = '0;
  logic [P*W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] model [N];

  always #4 clk = ~clk;

  onehot_regfile u_onehot_regfile (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  // behavioural model: commit writes at the edge
  always @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < N; i++) if (wr_sel[i]) model[i] <= wr_data;
    end
  end

  function automatic logic [W-1:0] expect_port(input logic [N-1:0] s);
    logic [W-1:0] r = '0;
    for (int i = 0; i < N; i++) begin
      if (s[i]) r = r | (wr_sel[i] ? wr_data : model[i]);
    end
    return r;
  endfunction

  task automatic check_ports(input string req);
    for (int k = 0; k < P; k++) begin
      logic [W-1:0] e = expect_port(rd_sel[k*N +: N]);
      logic [W-1:0] a = rd_data[k*W +: W];
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s port%0d: actual %h expected %h", req, k, a, e);
      end
    end
  endtask

  task automatic cyc(input logic [N-1:0] ws, input logic [W-1:0] wd,
                     input logic [N-1:0] r0, input logic [N-1:0] r1,
                     input string req);
    @(negedge clk);
    wr_sel = ws; wr_data = wd; rd_sel = {r1, r0};
    #1 check_ports(req);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'hACE1_1234;
    // R4 during reset: idle ports read zero
    repeat (3) begin
      @(negedge clk); #1;
      checks++;
      if (rd_data !== '0) begin
        errors++;
        $display("FAIL R4 reset idle: actual %h expected 0", rd_data);
      end
    end
    @(negedge clk) rst = 1'b0;
    // R1 R9: write every entry with a distinct value; each write forwarded (R3)
    for (int i = 0; i < N; i++)
      cyc(N'(1) << i, 32'h1000_0000 + 32'(i) * 32'h0101, N'(1) << i, '0, "R3 fwd on fill");
    // R1 R9: read back each entry on both ports
    for (int i = 0; i < N; i++)
      cyc('0, 32'hDEAD_BEEF, N'(1) << i, N'(1) << (N - 1 - i), "R1 R9 readback");
    // R2: all-zero write vector with junk data changes nothing
    cyc('0, 32'hFFFF_FFFF, 8'h04, 8'h20, "R2 no write");
    cyc('0, 32'h0, 8'h04, 8'h20, "R2 unchanged after");
    // R4: idle ports after reset
    cyc('0, 32'h5555_5555, '0, '0, "R4 idle zero");
    // R4 with a write in flight: idle port still zero
    cyc(8'h08, 32'hCAFE_0003, '0, 8'h08, "R4 idle during write");
    // R3: both ports read the entry being written
    cyc(8'h02, 32'h0BAD_F00D, 8'h02, 8'h02, "R3 forward");
    cyc('0, 32'h0, 8'h02, 8'h08, "R1 committed after forward");
    // R5: ports read two entries while a third is written
    cyc(8'h80, 32'h7777_0007, 8'h01, 8'h40, "R5 independent");
    cyc('0, 32'h0, 8'h80, 8'h01, "R5 third committed");
    // R6: change select mid-cycle, output follows at once
    @(negedge clk);
    wr_sel = '0; rd_sel = {8'h00, 8'h10};
    #1 check_ports("R6 zero latency a");
    rd_sel = {8'h20, 8'h04};
    #1 check_ports("R6 zero latency b");
    // R7: multi-bit reads OR stored and forwarded entries
    cyc('0, 32'h0, 8'h03, 8'hFF, "R7 OR stored");
    cyc(8'h04, 32'hF000_000F, 8'h06, 8'h0C, "R7 OR with forward");
    // R8: multi-bit write
    cyc(8'h30, 32'h1234_5678, '0, '0, "R8 multi write");
    cyc('0, 32'h0, 8'h10, 8'h20, "R8 both entries written");
    // pseudo-random traffic, compared to the model every cycle
    for (int t = 0; t < 300; t++) begin
      logic [N-1:0] ws, r0, r1;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ws = lfsr[3] ? (N'(1) << lfsr[6:4]) : '0;
      r0 = lfsr[7] ? (N'(1) << lfsr[10:8]) : (lfsr[11] ? lfsr[19:12] : '0);
      r1 = lfsr[20] ? (N'(1) << lfsr[23:21]) : '0;
      cyc(ws, lfsr ^ 32'h9E37_79B9, r0, r1, "R1 R3 R5 R7 random");
    end
    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule